// File: doc/BRIEF.md
# Mipmap Chain Bounds Checker

This block checks that a texture descriptor fits inside its backing buffer before the sampler is allowed to use it. It takes two descriptor words, the pixel size, a linear-or-tiled flag, the base offset of the image inside the buffer and the buffer length. From these it works out the footprint of every mip level and reports whether the whole chain fits.

The base level sits at the given offset and must end inside the buffer. The smaller levels are stored below the base offset, toward the buffer start. Each level's size is taken from a running budget, which starts at the base offset. A tiled chain uses the large tiled layout while a level is big. It falls back to the small microtile-raster layout once either dimension becomes small, and stays in that layout for the rest of the chain. Each layout pads the level dimensions to its own granule.

The check is sequential. A start pulse launches a job, one level is evaluated per clock, and a done pulse presents the verdict. The verdict comes with the index of the last level looked at, that level's padded dimensions and its layout.

Top module: `mip_fit_checker`

## Requirements
- R1: Base width is `cfg_word1[18:8]`, base height is `cfg_word1[30:20]` and the highest mip index is `cfg_word0[3:0]`; all other bits of both words have no effect on the result.
- R2: `pix_size` encodes bytes per pixel as 0→1, 1→2, 2→4, 3→8. A microtile is 8×8 pixels for 1 byte, 8×4 for 2 bytes, 4×4 for 4 bytes and 2×4 for 8 bytes (width×height).
- R3: With `tiled`=0 every level uses the linear layout: width padded up to a multiple of 16/bytes-per-pixel pixels, height unpadded.
- R4: With `tiled`=1 a level uses the small layout when its width ≤ 4 microtile widths or its height ≤ 4 microtile heights, otherwise the large layout. Once a level of a job uses the small layout, every later level of that job does too.
- R5: The large layout pads width and height to multiples of 8 microtile widths/heights; the small layout pads them to multiples of one microtile width/height.
- R6: Level i has width max(base_w >> i, 1) and height max(base_h >> i, 1). Its size in bytes is padded width × bytes per pixel × padded height, computed without wraparound.
- R7: Level 0 fails when the base width is zero, or when its size + `base_offset` (computed without wraparound) exceeds `buf_bytes`. A sum equal to `buf_bytes` passes.
- R8: Levels 1 to the mip index are checked in order against a running budget that starts at `base_offset`. A level fails when the budget is smaller than its size; otherwise its size is subtracted. A budget equal to the size passes.
- R9: A `start` seen while idle begins a job and raises `busy` on the next cycle. The job evaluates one level per cycle, starting at level 0, and stops at the first failing level or after the last level. The `done` pulse lasts one cycle and appears F+2 cycles after the `start` cycle, where F is the last level evaluated; `busy` drops together with it. A `start` while busy is ignored.
- R10: At `done`, `res_ok` is the verdict and `res_level` is the last level evaluated. `res_w`/`res_h` are that level's padded dimensions, and `res_layout` is its layout (0 linear, 1 large tiled, 2 small tiled). These results hold until the next `done`, and all outputs are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a check (taken only when idle) |
| cfg_word0 | input | 32 | Descriptor word carrying the mip index |
| cfg_word1 | input | 32 | Descriptor word carrying width and height |
| pix_size | input | 2 | Bytes-per-pixel code |
| tiled | input | 1 | 1 = tiled chain, 0 = linear |
| base_offset | input | 32 | Byte offset of level 0 in the buffer |
| buf_bytes | input | 32 | Buffer length in bytes |
| busy | output | 1 | A job is being evaluated |
| done | output | 1 | One-cycle pulse: results valid |
| res_ok | output | 1 | 1 = whole chain fits |
| res_level | output | 4 | Last level evaluated |
| res_w | output | 12 | Padded width of that level |
| res_h | output | 12 | Padded height of that level |
| res_layout | output | 2 | Layout of that level |

## Verification
Jobs cover all four pixel sizes, both linear and tiled chains, and square, tall and wide bases. This separates the microtile shapes and the three padding rules. Budgets are set exactly equal to the chain footprint and one byte short, and buffer lengths exactly equal to the base footprint and one byte short. These cases tell a strict comparison from a non-strict one, and they make the failing level index depend on the order of subtraction. One tiled job is cut off right where the chain drops to the small layout, which shows the per-level switch. Other jobs use dirty descriptor bits, a wrapping base offset, a zero width, and a second start during a running job.

// File: rtl/mfc_pkg.sv
`timescale 1ns/1ps
package mfc_pkg;

    typedef enum logic [1:0] {
        LAYOUT_LINEAR = 2'd0,
        LAYOUT_LARGE  = 2'd1,
        LAYOUT_SMALL  = 2'd2
    } layout_e;

    // log2 of microtile width in pixels for a bytes-per-pixel code
    function automatic logic [2:0] utile_w_log2(input logic [1:0] pix);
        case (pix)
            2'd0, 2'd1: utile_w_log2 = 3'd3;
            2'd2:       utile_w_log2 = 3'd2;
            default:    utile_w_log2 = 3'd1;
        endcase
    endfunction

    // log2 of microtile height in pixels for a bytes-per-pixel code
    function automatic logic [2:0] utile_h_log2(input logic [1:0] pix);
        utile_h_log2 = (pix == 2'd0) ? 3'd3 : 3'd2;
    endfunction

endpackage

// File: rtl/mfc_layout_pick.sv
`timescale 1ns/1ps
module mfc_layout_pick
    import mfc_pkg::*;
#(
    parameter int DIM_W = 11
) (
    input  logic             tiled,
    input  logic             small_seen,
    input  logic [1:0]       pix,
    input  logic [DIM_W-1:0] lvl_w,
    input  logic [DIM_W-1:0] lvl_h,
    output layout_e          layout
);
    localparam int CW = DIM_W + 4;

    logic [CW-1:0] lim_w, lim_h;
    logic          is_small;

    always_comb begin
        lim_w    = CW'(4) << utile_w_log2(pix);
        lim_h    = CW'(4) << utile_h_log2(pix);
        is_small = (CW'(lvl_w) <= lim_w) || (CW'(lvl_h) <= lim_h);
        if (!tiled)
            layout = LAYOUT_LINEAR;
        else if (small_seen || is_small)
            layout = LAYOUT_SMALL;
        else
            layout = LAYOUT_LARGE;
    end
endmodule

// File: rtl/mfc_level_sizer.sv
`timescale 1ns/1ps
module mfc_level_sizer
    import mfc_pkg::*;
#(
    parameter int DIM_W  = 11,
    parameter int SIZE_W = 2 * (DIM_W + 1) + 3
) (
    input  layout_e           layout,
    input  logic [1:0]        pix,
    input  logic [DIM_W-1:0]  lvl_w,
    input  logic [DIM_W-1:0]  lvl_h,
    output logic [DIM_W:0]    pad_w,
    output logic [DIM_W:0]    pad_h,
    output logic [SIZE_W-1:0] bytes
);
    localparam int AW = DIM_W + 1;

    logic [2:0]    gw, gh;
    logic [AW-1:0] mask_w, mask_h;
    logic [SIZE_W-1:0] row_bytes;

    always_comb begin
        case (layout)
            LAYOUT_LARGE: begin
                gw = utile_w_log2(pix) + 3'd3;
                gh = utile_h_log2(pix) + 3'd3;
            end
            LAYOUT_SMALL: begin
                gw = utile_w_log2(pix);
                gh = utile_h_log2(pix);
            end
            default: begin
                gw = 3'd4 - {1'b0, pix};
                gh = 3'd0;
            end
        endcase
        mask_w    = (AW'(1) << gw) - AW'(1);
        mask_h    = (AW'(1) << gh) - AW'(1);
        pad_w     = (AW'(lvl_w) + mask_w) & ~mask_w;
        pad_h     = (AW'(lvl_h) + mask_h) & ~mask_h;
        row_bytes = SIZE_W'(pad_w) << pix;
        bytes     = row_bytes * SIZE_W'(pad_h);
    end
endmodule

// File: rtl/mip_fit_checker.sv
`timescale 1ns/1ps
module mip_fit_checker
    import mfc_pkg::*;
#(
    parameter int DIM_W  = 11,
    parameter int MIP_W  = 4,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [31:0]       cfg_word0,
    input  logic [31:0]       cfg_word1,
    input  logic [1:0]        pix_size,
    input  logic              tiled,
    input  logic [ADDR_W-1:0] base_offset,
    input  logic [ADDR_W-1:0] buf_bytes,
    output logic              busy,
    output logic              done,
    output logic              res_ok,
    output logic [MIP_W-1:0]  res_level,
    output logic [DIM_W:0]    res_w,
    output logic [DIM_W:0]    res_h,
    output logic [1:0]        res_layout
);
    localparam int W_LSB  = 8;
    localparam int H_LSB  = 20;
    localparam int SIZE_W = 2 * (DIM_W + 1) + 3;
    localparam int WIDE_W = ADDR_W + SIZE_W + 1;

    typedef enum logic {ST_IDLE, ST_RUN} st_e;

    typedef struct packed {
        st_e              st;
        logic [MIP_W-1:0] lvl;
        logic [MIP_W-1:0] top;
        logic [DIM_W-1:0] bw;
        logic [DIM_W-1:0] bh;
        logic [1:0]       pix;
        logic             tiled;
        logic             small_seen;
        logic [ADDR_W-1:0] budget;
        logic [ADDR_W-1:0] limit;
        logic             done;
        logic             ok;
        logic [MIP_W-1:0] rlvl;
        logic [DIM_W:0]   rw;
        logic [DIM_W:0]   rh;
        layout_e          rlay;
    } state_t;

    state_t s_d, s_q;

    logic [DIM_W-1:0]  shr_w, shr_h, lvl_w, lvl_h;
    layout_e           lay;
    logic [DIM_W:0]    pad_w, pad_h;
    logic [SIZE_W-1:0] lvl_bytes;
    logic [WIDE_W-1:0] end_pos;
    logic              lvl_fail;

    always_comb begin
        shr_w = s_q.bw >> s_q.lvl;
        shr_h = s_q.bh >> s_q.lvl;
        lvl_w = (shr_w == '0) ? DIM_W'(1) : shr_w;
        lvl_h = (shr_h == '0) ? DIM_W'(1) : shr_h;
    end

    mfc_layout_pick #(.DIM_W(DIM_W)) u_pick (
        .tiled      (s_q.tiled),
        .small_seen (s_q.small_seen),
        .pix        (s_q.pix),
        .lvl_w      (lvl_w),
        .lvl_h      (lvl_h),
        .layout     (lay)
    );

    mfc_level_sizer #(.DIM_W(DIM_W), .SIZE_W(SIZE_W)) u_size (
        .layout (lay),
        .pix    (s_q.pix),
        .lvl_w  (lvl_w),
        .lvl_h  (lvl_h),
        .pad_w  (pad_w),
        .pad_h  (pad_h),
        .bytes  (lvl_bytes)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        end_pos  = WIDE_W'(lvl_bytes) + WIDE_W'(s_q.budget);
        if (s_q.lvl == '0)
            lvl_fail = (s_q.bw == '0) || (end_pos > WIDE_W'(s_q.limit));
        else
            lvl_fail = WIDE_W'(s_q.budget) < WIDE_W'(lvl_bytes);

        case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    s_d.st         = ST_RUN;
                    s_d.lvl        = '0;
                    s_d.top        = cfg_word0[MIP_W-1:0];
                    s_d.bw         = cfg_word1[W_LSB +: DIM_W];
                    s_d.bh         = cfg_word1[H_LSB +: DIM_W];
                    s_d.pix        = pix_size;
                    s_d.tiled      = tiled;
                    s_d.small_seen = 1'b0;
                    s_d.budget     = base_offset;
                    s_d.limit      = buf_bytes;
                end
            end
            default: begin
                s_d.small_seen = s_q.small_seen || (lay == LAYOUT_SMALL);
                if (s_q.lvl != '0 && !lvl_fail)
                    s_d.budget = s_q.budget - ADDR_W'(lvl_bytes);
                if (lvl_fail || s_q.lvl == s_q.top) begin
                    s_d.st   = ST_IDLE;
                    s_d.done = 1'b1;
                    s_d.ok   = !lvl_fail;
                    s_d.rlvl = s_q.lvl;
                    s_d.rw   = pad_w;
                    s_d.rh   = pad_h;
                    s_d.rlay = lay;
                end else begin
                    s_d.lvl = s_q.lvl + MIP_W'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy       = (s_q.st == ST_RUN);
    assign done       = s_q.done;
    assign res_ok     = s_q.ok;
    assign res_level  = s_q.rlvl;
    assign res_w      = s_q.rw;
    assign res_h      = s_q.rh;
    assign res_layout = s_q.rlay;
endmodule

// File: rtl/mfc_checker.sv
`timescale 1ns/1ps
module mfc_checker #(
    parameter int DIM_W = 11,
    parameter int MIP_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             res_ok,
    input logic [MIP_W-1:0] res_level,
    input logic [DIM_W:0]   res_w,
    input logic [DIM_W:0]   res_h,
    input logic [1:0]       res_layout
);
    // R9: done is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: a job only begins from a start request
    a_r9_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R9: busy ends exactly when done is presented
    a_r9_busy_ends: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R5: large layout widths are multiples of 16, heights of 32 for every pixel size
    a_r5_large_pad: assert property (@(posedge clk) disable iff (!rst_n)
        (done && res_layout == 2'd1) |-> (res_w[3:0] == 4'd0 && res_h[4:0] == 5'd0));

    // R3: a linear width is always padded to at least a multiple of 2
    a_r3_linear_pad: assert property (@(posedge clk) disable iff (!rst_n)
        (done && res_layout == 2'd0) |-> (res_w[0] == 1'b0));

    // R10: results hold between done pulses
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable({res_ok, res_level, res_w, res_h, res_layout}));
endmodule

bind mip_fit_checker mfc_checker #(.DIM_W(DIM_W), .MIP_W(MIP_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .res_ok     (res_ok),
    .res_level  (res_level),
    .res_w      (res_w),
    .res_h      (res_h),
    .res_layout (res_layout)
);

// File: tb/mip_fit_checker_test.sv
`timescale 1ns/1ps
module mip_fit_checker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] cfg_word0 = '0, cfg_word1 = '0;
    logic [1:0]  pix_size = '0;
    logic        tiled = 1'b0;
    logic [31:0] base_offset = '0, buf_bytes = '0;
    logic        busy, done, res_ok;
    logic [3:0]  res_level;
    logic [11:0] res_w, res_h;
    logic [1:0]  res_layout;

    always #2.5 clk = ~clk;

    mip_fit_checker uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_word0(cfg_word0), .cfg_word1(cfg_word1),
        .pix_size(pix_size), .tiled(tiled),
        .base_offset(base_offset), .buf_bytes(buf_bytes),
        .busy(busy), .done(done), .res_ok(res_ok), .res_level(res_level),
        .res_w(res_w), .res_h(res_h), .res_layout(res_layout)
    );

    typedef struct {
        bit     ok;
        int     lvl;
        int     w;
        int     h;
        int     lay;
        int     start_cyc;
        string  tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0, n_fail = 0, n_stray = 0, cyc = 0, n_done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit good, input string req, input string what,
                       input longint act, input longint expv);
        n_checks++;
        if (!good) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Level geometry from the requirements (R2-R6)
    function automatic void lvl_info(input int bw, input int bh, input int pix,
                                     input bit tl, input int L, output longint sz,
                                     output int aw, output int ah, output int md);
        int uw, uh, cpp, w, h, gw, gh;
        bit seen;
        uw = (pix == 3) ? 2 : (pix == 2) ? 4 : 8;
        uh = (pix == 0) ? 8 : 4;
        cpp = 1 << pix;
        seen = 0; md = 0; w = 1; h = 1;
        for (int i = 0; i <= L; i++) begin
            w = bw >> i; if (w < 1) w = 1;
            h = bh >> i; if (h < 1) h = 1;
            if (!tl) md = 0;
            else if (seen || w <= 4*uw || h <= 4*uh) begin md = 2; seen = 1; end
            else md = 1;
        end
        if (md == 0) begin gw = 16 / cpp; gh = 1; end
        else if (md == 1) begin gw = 8*uw; gh = 8*uh; end
        else begin gw = uw; gh = uh; end
        aw = ((w + gw - 1) / gw) * gw;
        ah = ((h + gh - 1) / gh) * gh;
        sz = longint'(aw) * cpp * ah;
    endfunction

    function automatic longint chain_sum(input int bw, input int bh, input int pix,
                                         input bit tl, input int from, input int upto);
        longint s, sz;
        int aw, ah, md;
        s = 0;
        for (int L = from; L <= upto; L++) begin
            lvl_info(bw, bh, pix, tl, L, sz, aw, ah, md);
            s += sz;
        end
        return s;
    endfunction

    // Verdict from the requirements (R1, R7, R8)
    function automatic exp_t model(input logic [31:0] p0, input logic [31:0] p1,
                                   input int pix, input bit tl,
                                   input longint off, input longint lim);
        exp_t e;
        int bw, bh, m, aw, ah, md;
        longint sz, budget;
        bit fl;
        bw = int'((p1 >> 8) & 32'h7FF);
        bh = int'((p1 >> 20) & 32'h7FF);
        m  = int'(p0 & 32'hF);
        budget = off;
        e.ok = 1; e.lvl = 0; e.w = 0; e.h = 0; e.lay = 0;
        for (int L = 0; L <= m; L++) begin
            lvl_info(bw, bh, pix, tl, L, sz, aw, ah, md);
            if (L == 0) fl = (bw == 0) || (sz + off > lim);
            else begin
                fl = budget < sz;
                if (!fl) budget -= sz;
            end
            e.lvl = L; e.w = aw; e.h = ah; e.lay = md; e.ok = !fl;
            if (fl) break;
        end
        return e;
    endfunction

    task automatic run_job(input string tag, input logic [31:0] p0, input logic [31:0] p1,
                           input int pix, input bit tl, input longint off, input longint lim);
        exp_t e;
        int target;
        e = model(p0, p1, pix, tl, off, lim);
        e.tag = tag;
        @(negedge clk);
        cfg_word0 = p0; cfg_word1 = p1; pix_size = 2'(pix); tiled = tl;
        base_offset = 32'(off); buf_bytes = 32'(lim);
        e.start_cyc = cyc;
        exp_q.push_back(e);
        target = n_done + 1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (n_done < target) @(negedge clk);
    endtask

    // Monitor: pops expected results as done pulses appear
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) n_stray++;
            else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(res_ok == e.ok, e.tag, "verdict", res_ok, e.ok);
                chk(res_level == 4'(e.lvl), e.tag, "level", res_level, e.lvl);
                chk(res_w == 12'(e.w), e.tag, "padded width", res_w, e.w);
                chk(res_h == 12'(e.h), e.tag, "padded height", res_h, e.h);
                chk(res_layout == 2'(e.lay), "R4", "layout", res_layout, e.lay);
                chk(cyc - e.start_cyc == e.lvl + 2, "R9", "latency",
                    cyc - e.start_cyc, e.lvl + 2);
            end
            n_done++;
        end
    end

    function automatic logic [31:0] dims(input int w, input int h);
        return (32'(h) << 20) | (32'(w) << 8);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        longint s;
        int aw, ah, md, jobs_before;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk({busy, done, res_ok, res_level, res_w, res_h, res_layout} == '0,
            "R10", "reset outputs", {busy, done, res_ok}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R9", "idle busy", busy, 0);

        // R3: linear, 4-byte pixels
        run_job("R3", 32'd0, dims(100, 50), 2, 0, 0, 1 << 20);
        // R3: linear, 2-byte pixels, mip chain
        run_job("R3", 32'd2, dims(33, 7), 1, 0, 4096, 1 << 20);
        // R3: linear, 8-byte pixels, odd height kept
        run_job("R3", 32'd0, dims(5, 3), 3, 0, 0, 1000);
        // R8: tiled full chain, budget exactly equal
        s = chain_sum(256, 256, 2, 1, 1, 8);
        run_job("R8", 32'd8, dims(256, 256), 2, 1, s, s + 300000);
        // R8: one byte short, fails at the last level
        run_job("R8", 32'd8, dims(256, 256), 2, 1, s - 1, s + 300000);
        // R4: cut off at the level where the chain turns small
        s = chain_sum(128, 128, 2, 1, 1, 2);
        lvl_info(128, 128, 2, 1, 3, s, aw, ah, md);
        s = chain_sum(128, 128, 2, 1, 1, 2) + s - 1;
        run_job("R4", 32'd4, dims(128, 128), 2, 1, s, s + 100000);
        // R7: base exactly fits, then one byte over
        run_job("R7", 32'd0, dims(64, 64), 2, 1, 1000, 1000 + 16384);
        run_job("R7", 32'd0, dims(64, 64), 2, 1, 1000, 1000 + 16383);
        // R7: wrapping offset
        run_job("R7", 32'd0, dims(64, 64), 2, 1, 64'hFFFF_FF00, 64'hFFFF_FFFF);
        // R7: zero width
        run_job("R7", 32'd0, dims(0, 64), 2, 1, 0, 1 << 20);
        // R2/R5: 1-byte and 8-byte tiled chains
        run_job("R5", 32'd3, dims(200, 40), 0, 1, 1 << 20, 1 << 22);
        run_job("R2", 32'd5, dims(70, 300), 3, 1, 1 << 20, 1 << 22);
        // R6: deep chain to 1x1 on a wide base
        run_job("R6", 32'd10, dims(2047, 3), 1, 1, 1 << 20, 1 << 22);
        // R1: dirty bits outside the fields
        run_job("R1", 32'hABCD_EF03, dims(200, 40) | 32'h8008_00FF, 0, 1, 1 << 20, 1 << 22);

        // R9: a second start during a running job is ignored
        jobs_before = n_done;
        fork
            run_job("R9", 32'd8, dims(256, 256), 2, 1, 1 << 20, 1 << 22);
            begin
                repeat (4) @(negedge clk);
                cfg_word1 = dims(8, 8);
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
        join
        repeat (12) @(negedge clk);
        chk(n_done - jobs_before == 1, "R9", "results per job", n_done - jobs_before, 1);
        chk(n_stray == 0, "R9", "stray done pulses", n_stray, 0);
        chk(exp_q.size() == 0, "R9", "missing results", exp_q.size(), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule